// File: doc/BRIEF.md
# Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core. The low eight logical registers exist twice, once in bank 0 and once in bank 1. The high eight are one shared set. A bank-select input, normally taken from the bank bit of the status word, decides which copy of registers 0 to 7 answers the two normal read ports and the normal write port. Because that bit is 1 after reset and is forced to 1 on exception entry, a handler starts on bank 1 and does not disturb the interrupted code's bank 0 values.

A third port, the alternate port, has a 3-bit index. It reads and writes registers 0 to 7 of the bank that is not selected. Special move instructions use it to save and restore the other context. The core decodes those instructions and decides whether the alternate port may be used. Register contents are never reset, so a register that has not been written reads back whatever it happens to hold.

Top module: `banked_regfile`

## Requirements
- R1: Logical registers 8 to 15 are one shared set. A normal read of index 8 to 15 returns the same value whatever the level of `bankSel`.
- R2: For normal reads and writes of index 0 to 7, the bank used equals the level of `bankSel` during that cycle: 1 selects bank 1 and 0 selects bank 0.
- R3: The alternate port reaches register `altIdx` (0 to 7) of bank `!bankSel`. `altRdData` returns that register, and a write stores `altWrData` into it.
- R4: Reads are combinational. A write takes effect at the rising clock edge, so a read of the register being written in the same cycle returns the old value, and the next cycle returns the new one.
- R5: An alternate write never changes the selected bank or the shared registers. A normal write never changes the unselected bank. The two writes can happen together in the same cycle.
- R6: The two normal read ports work independently. When they hold the same index they return the same data.
- R7: When `wrEn` and `altWrEn` are both 0, no register changes, whatever the data and index inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| bankSel | input | 1 | Selected bank for registers 0 to 7 |
| rdIdxA | input | 4 | Read port A logical index |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 4 | Read port B logical index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Normal write enable |
| wrIdx | input | 4 | Normal write logical index |
| wrData | input | 32 | Normal write data |
| altIdx | input | 3 | Alternate port index into the unselected bank |
| altWrEn | input | 1 | Alternate write enable |
| altWrData | input | 32 | Alternate write data |
| altRdData | output | 32 | Alternate port read data |

## Verification
The bench loads every register through both ports and then reads every logical index under both bank levels, using both read ports and the alternate port. A design that wired the shared registers into a bank would show different high-register values after a bank flip. A design that inverted the alternate port's bank would return the selected copy on `altRdData`. It writes the same low index through the normal port and the alternate port in one cycle. A design that let one write leak into the other bank would overwrite a value that should survive. It also reads a register in the cycle it is written, which exposes a write-through path that returns the new value one cycle early. Finally it holds the enables low while the data and index inputs change, which exposes any write that ignores its enable.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  // Configuration of the register file
  localparam int RF_DATA_W   = 32;
  localparam int RF_LOG_REGS = 16;
  localparam int RF_BANKED   = 8;
  // Derived sizes
  localparam int RF_SHARED   = RF_LOG_REGS - RF_BANKED;
  localparam int RF_PHYS     = 2 * RF_BANKED + RF_SHARED;
  localparam int RF_IDX_W    = $clog2(RF_LOG_REGS);
  localparam int RF_ALT_W    = $clog2(RF_BANKED);
  localparam int RF_PHYS_W   = $clog2(RF_PHYS);

  typedef logic [RF_PHYS_W-1:0] physIdx_t;
  typedef logic [RF_IDX_W-1:0]  logIdx_t;
  typedef logic [RF_DATA_W-1:0] word_t;

  // Strobes from control to datapath
  typedef struct packed {
    physIdx_t rdA;
    physIdx_t rdB;
    physIdx_t wr;
    logic     wrStb;
    physIdx_t alt;
    logic     altWrStb;
  } rfStrobes_t;
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import bankreg_pkg::*;
(
  input  logic                bankSel,
  input  logic [RF_IDX_W-1:0] rdIdxA,
  input  logic [RF_IDX_W-1:0] rdIdxB,
  input  logic                wrEn,
  input  logic [RF_IDX_W-1:0] wrIdx,
  input  logic [RF_ALT_W-1:0] altIdx,
  input  logic                altWrEn,
  output rfStrobes_t          strobes
);
  // Physical layout: bank 0 low copies, then bank 1 low copies, then shared
  function automatic physIdx_t mapIdx(input logic bank, input logIdx_t idx);
    int v;
    if (int'(idx) < RF_BANKED) begin
      v = (bank ? RF_BANKED : 0) + int'(idx);
    end else begin
      v = 2 * RF_BANKED + (int'(idx) - RF_BANKED);
    end
    return physIdx_t'(v);
  endfunction

  always_comb begin
    strobes.rdA      = mapIdx(bankSel, rdIdxA);
    strobes.rdB      = mapIdx(bankSel, rdIdxB);
    strobes.wr       = mapIdx(bankSel, wrIdx);
    strobes.wrStb    = wrEn;
    strobes.alt      = mapIdx(!bankSel, logIdx_t'(altIdx));
    strobes.altWrStb = altWrEn;
  end
endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
  import bankreg_pkg::*;
(
  input  logic       clk,
  input  rfStrobes_t strobes,
  input  word_t      wrData,
  input  word_t      altWrData,
  output word_t      rdDataA,
  output word_t      rdDataB,
  output word_t      altRdData
);
  word_t cells [RF_PHYS];

  for (genvar p = 0; p < RF_PHYS; p++) begin : g_cell
    word_t cellQ;
    // Normal port takes priority if both ever address one cell
    always_ff @(posedge clk) begin
      if (strobes.wrStb && strobes.wr == physIdx_t'(p)) begin
        cellQ <= wrData;
      end else if (strobes.altWrStb && strobes.alt == physIdx_t'(p)) begin
        cellQ <= altWrData;
      end
    end
    assign cells[p] = cellQ;
  end

  assign rdDataA   = cells[strobes.rdA];
  assign rdDataB   = cells[strobes.rdB];
  assign altRdData = cells[strobes.alt];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 bankSel,
  input  logic [RF_IDX_W-1:0]  rdIdxA,
  output logic [RF_DATA_W-1:0] rdDataA,
  input  logic [RF_IDX_W-1:0]  rdIdxB,
  output logic [RF_DATA_W-1:0] rdDataB,
  input  logic                 wrEn,
  input  logic [RF_IDX_W-1:0]  wrIdx,
  input  logic [RF_DATA_W-1:0] wrData,
  input  logic [RF_ALT_W-1:0]  altIdx,
  input  logic                 altWrEn,
  input  logic [RF_DATA_W-1:0] altWrData,
  output logic [RF_DATA_W-1:0] altRdData
);
  rfStrobes_t strobes;

  rf_bank_ctrl u_ctrl (
    .bankSel (bankSel),
    .rdIdxA  (rdIdxA),
    .rdIdxB  (rdIdxB),
    .wrEn    (wrEn),
    .wrIdx   (wrIdx),
    .altIdx  (altIdx),
    .altWrEn (altWrEn),
    .strobes (strobes)
  );

  rf_bank_store u_store (
    .clk       (clk),
    .strobes   (strobes),
    .wrData    (wrData),
    .altWrData (altWrData),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .altRdData (altRdData)
  );
endmodule

// File: rtl/rf_bank_checker.sv
module rf_bank_checker
  import bankreg_pkg::*;
(
  input logic                 clk,
  input logic                 bankSel,
  input logic [RF_IDX_W-1:0]  rdIdxA,
  input logic [RF_DATA_W-1:0] rdDataA,
  input logic [RF_IDX_W-1:0]  rdIdxB,
  input logic [RF_DATA_W-1:0] rdDataB,
  input logic                 wrEn,
  input logic [RF_IDX_W-1:0]  wrIdx,
  input logic [RF_DATA_W-1:0] wrData,
  input logic [RF_ALT_W-1:0]  altIdx,
  input logic                 altWrEn,
  input logic [RF_DATA_W-1:0] altWrData,
  input logic [RF_DATA_W-1:0] altRdData
);
  // No reset port: arm the checks after two clock edges
  logic [1:0] armCnt = 2'd0;
  always_ff @(posedge clk) begin
    if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
  end
  logic armed;
  assign armed = (armCnt == 2'd2);

  // R4, R2: a normal write is visible on port A next cycle under the same bank
  p_write_visible_r4: assert property (@(posedge clk) disable iff (!armed)
    ($past(wrEn) && rdIdxA == $past(wrIdx) &&
     (int'(rdIdxA) >= RF_BANKED || bankSel == $past(bankSel)))
    |-> rdDataA == $past(wrData));

  // R3: after a bank flip, the old alternate view becomes the selected view
  p_alt_view_r3: assert property (@(posedge clk) disable iff (!armed)
    (bankSel != $past(bankSel) && !$past(wrEn) && !$past(altWrEn) &&
     int'(rdIdxA) < RF_BANKED && rdIdxA == logIdx_t'($past(altIdx)))
    |-> rdDataA == $past(altRdData));

  // R1: shared registers do not move with the bank when nothing is written
  p_shared_stable_r1: assert property (@(posedge clk) disable iff (!armed)
    (int'(rdIdxA) >= RF_BANKED && rdIdxA == $past(rdIdxA) && !$past(wrEn))
    |-> $stable(rdDataA));

  // R6: equal indices give equal data on both read ports
  p_ports_agree_r6: assert property (@(posedge clk) disable iff (!armed)
    (rdIdxA == rdIdxB) |-> rdDataA == rdDataB);

  // R7: no enable, no change on a held alternate view
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!armed)
    (!$past(wrEn) && !$past(altWrEn) && altIdx == $past(altIdx) &&
     bankSel == $past(bankSel))
    |-> $stable(altRdData));
endmodule

bind banked_regfile rf_bank_checker u_chk (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        bankSel = 1'b1;
  logic [3:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [31:0] rdDataA, rdDataB, altRdData;
  logic        wrEn = 1'b0, altWrEn = 1'b0;
  logic [31:0] wrData = '0, altWrData = '0;
  logic [2:0]  altIdx = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Model: [0..7] bank 0, [8..15] bank 1, [16..23] shared
  logic [31:0] model [24];

  always #2.5 clk = ~clk;

  banked_regfile u_dut (.*);

  function automatic int slot(input bit b, input int idx);
    return (idx < 8) ? (b ? 8 + idx : idx) : 16 + idx - 8;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic normalWrite(input bit b, input int idx, input logic [31:0] d);
    @(negedge clk);
    bankSel = b; wrIdx = 4'(idx); wrData = d; wrEn = 1'b1;
    @(posedge clk); #0.5;
    wrEn = 1'b0;
    model[slot(b, idx)] = d;
  endtask

  // Read every index through every port under both banks
  task automatic sweepAll(input string tag);
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        bankSel = b[0]; rdIdxA = 4'(i); rdIdxB = 4'(15 - i); altIdx = 3'(i % 8);
        #1;
        chk(rdDataA, model[slot(b[0], i)], (i < 8) ? {"R2 ", tag} : {"R1 ", tag});
        chk(rdDataB, model[slot(b[0], 15 - i)], {"R6 ", tag});
        chk(altRdData, model[slot(!b[0], i % 8)], {"R3 ", tag});
      end
    end
  endtask

  initial begin
    // Fill both banks and the shared set through the normal port
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++)
        normalWrite(b[0], i, 32'hA500_0000 ^ (b << 12) ^ (i * 32'h0101_0011));
    sweepAll("fill");

    // Same index on both ports in one cycle: normal to bank 0, alternate to bank 1
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      bankSel = 1'b0; wrEn = 1'b1; wrIdx = 4'(k); wrData = 32'h1100_0000 + k;
      altWrEn = 1'b1; altIdx = 3'(k); altWrData = 32'h2200_0000 + k;
      @(posedge clk); #0.5;
      wrEn = 1'b0; altWrEn = 1'b0;
      model[slot(1'b0, k)] = 32'h1100_0000 + k;
      model[slot(1'b1, k)] = 32'h2200_0000 + k;
    end
    sweepAll("R5 dual write");

    // Alternate writes with bank 1 selected land in bank 0 only
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      bankSel = 1'b1; altWrEn = 1'b1; altIdx = 3'(k); altWrData = 32'h3300_0000 ^ (k << 4);
      @(posedge clk); #0.5;
      altWrEn = 1'b0;
      model[slot(1'b0, k)] = 32'h3300_0000 ^ (k << 4);
    end
    sweepAll("R5 alt only");

    // Same-cycle read returns old value, next cycle returns new
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk);
      bankSel = 1'b1; rdIdxA = 4'(i); wrIdx = 4'(i); wrData = 32'hC0DE_0000 + i; wrEn = 1'b1;
      #1;
      chk(rdDataA, model[slot(1'b1, i)], "R4 old value");
      @(posedge clk); #0.5;
      wrEn = 1'b0;
      model[slot(1'b1, i)] = 32'hC0DE_0000 + i;
      #1;
      chk(rdDataA, model[slot(1'b1, i)], "R4 new value");
    end

    // Enables low while data and indices move
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bankSel = i[0]; wrIdx = 4'(i); wrData = 32'hDEAD_BEEF; altIdx = 3'(i % 8);
      altWrData = 32'hFEED_F00D;
    end
    sweepAll("R7 idle");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule